// File: doc/BRIEF.md
# Four-Channel Programmable Counter/Timer

This peripheral has four channels that work independently of each other. Each channel is built around an 8-bit down-counter that software can read back at any time. A channel runs in one of two modes:

- **Timer mode:** the system clock drives the counter through a prescaler that divides by 16 or by 256.
- **Counter mode:** edges on the channel's trigger input drive the counter. Software picks the rising or the falling edge.

When a channel reaches zero it reloads its time constant and keeps counting. At that moment it can also raise an interrupt.

Software controls the block through a small register bus: chip select, a 2-bit channel select, read and write strobes, and byte-wide data. A byte whose bit 0 is set is a control word. Its other bits carry the channel's options. When a control word announces a time constant, the next write to that channel delivers the constant.

The zero events of channels 0 to 2 appear as one-clock pulses on dedicated outputs. All four channels feed a fixed-priority interrupt request that comes with a vector. The vector carries the number of the channel being served, so the block also works as a small vectored interrupt controller.

Top module: `quad_counter_timer`

## Requirements
- R1: After reset every channel is stopped. Every channel reads back 0, `irqReq` is low, `zeroOut` is all zero, and the vector base is 0.
- R2: A write with bit 0 = 1 is a control word. Its bits are: 7 interrupt enable, 6 counter mode (0 = timer), 5 prescale 256 (0 = 16), 4 rising edge active (0 = falling), 3 timer waits for a trigger edge, 2 a time constant follows, 1 software reset. After a control word with bit 2 set, the next write to that channel is taken as the time constant. If the channel is stopped, that write loads the counter and starts the channel.
- R3: While `cs` and `rdEn` are high, `rdData` shows the selected channel's counter in the same cycle; otherwise it shows 0. Reading never changes the count.
- R4: In timer mode the counter decrements once every 16 system clocks, or once every 256 with the prescale bit set. The first decrement comes 16 (or 256) clocks after the channel starts.
- R5: A decrement from 1 reloads the counter from the time constant, and counting goes on. A time constant of 0 counts as 256.
- R6: In counter mode, each active edge of `trigIn` (rising or falling, as the control word selects) decrements the counter. The count changes within three clocks of the edge, after a two-stage synchroniser.
- R7: A timer with the trigger-start bit set loads its constant, holds the count, and starts prescaling only on the first active trigger edge after that load.
- R8: `zeroOut[i]` for channels 0 to 2 goes high for exactly one clock at each reload of that channel. Channel 3 has no such output.
- R9: A control word with the software reset bit stops the channel and freezes its count until a new time constant is written. Interrupts already pending stay pending.
- R10: A reload on a channel whose interrupt is enabled sets that channel's pending flag. `irqReq` is high while any flag is set. `vecOut` = {base in bits 7:3, number of the lowest-numbered pending channel in bits 2:1, 0 in bit 0}. An `intAck` pulse clears only the flag named by the vector.
- R11: A write with bit 0 = 0 to channel 0, when channel 0 expects no time constant, sets the vector base from bits 7:3. The same write to any other channel is ignored.
- R12: A time constant written to a running channel changes only the reload value. The current count goes on undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for register access |
| chanSel | input | 2 | Channel addressed by a read or write |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe, sampled on the clock edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read-back of the selected counter |
| trigIn | input | 4 | Per-channel trigger / event inputs |
| zeroOut | output | 3 | One-clock zero-count pulses of channels 0 to 2 |
| irqReq | output | 1 | Interrupt request |
| intAck | input | 1 | Interrupt acknowledge pulse |
| vecOut | output | 8 | Vector of the highest-priority pending channel |

## Verification
Some behaviour can be stated as a rule about any two adjacent cycles, and the embedded assertions watch those rules on every cycle:
- a zero pulse never lasts two clocks;
- a reload always takes the stored constant;
- a stopped channel never moves;
- a pending interrupt is only ever cleared by an acknowledge aimed at it;
- the vector always names the lowest pending channel.

Other behaviour only shows up over many cycles, so the bench's scenarios have to show it:
- the actual prescale periods;
- edge polarity;
- the 256 meaning of a zero constant;
- the delayed start of a triggered timer;
- the decoding of control and vector-base writes;
- that a new constant on a running channel waits for the next reload.

// File: rtl/qct_pkg.sv
package qct_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 4;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int VBASE_W = DATA_W - CH_W - 1;

  // control word bit positions
  localparam int CW_FLAG = 0;
  localparam int CW_RST  = 1;
  localparam int CW_TCF  = 2;
  localparam int CW_TRIG = 3;
  localparam int CW_RISE = 4;
  localparam int CW_SLOW = 5;
  localparam int CW_CNT  = 6;
  localparam int CW_IRQ  = 7;

  typedef struct packed {
    logic irqEn;
    logic cntMode;
    logic slowPre;
    logic riseEdge;
    logic trigStart;
  } chanCfg_t;

  typedef struct packed {
    logic              halt;
    logic              loadTc;
    logic [DATA_W-1:0] tcVal;
  } chanCmd_t;

  typedef struct packed {
    chanCmd_t [NUM_CH-1:0] ch;
    logic                  rdGo;
    logic [CH_W-1:0]       rdSel;
  } dpStrobe_t;

  typedef enum logic [1:0] {CH_IDLE, CH_ARMED, CH_RUN} chanState_t;
endpackage

// File: rtl/qct_channel.sv
module qct_channel
  import qct_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FAST_LOG    = 4,
  parameter int SLOW_LOG    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanCfg_t          cfg,
  input  chanCmd_t          cmd,
  input  logic              trigIn,
  output logic [DATA_W-1:0] count,
  output logic              zeroPulse
);
  localparam int PRE_W = SLOW_LOG;

  chanState_t        state;
  logic [DATA_W-1:0] tcReg;
  logic [PRE_W-1:0]  preCnt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic              trigPrev;
  logic              trigLvl;
  logic              activeEdge;
  logic              preLast;
  logic              decrement;
  logic              hitZero;

  assign trigLvl    = syncQ[SYNC_STAGES-1];
  assign activeEdge = cfg.riseEdge ? (trigLvl & ~trigPrev) : (~trigLvl & trigPrev);
  assign preLast    = cfg.slowPre ? (preCnt == {PRE_W{1'b1}})
                                  : (preCnt[FAST_LOG-1:0] == {FAST_LOG{1'b1}});
  assign decrement  = (state == CH_RUN) && (cfg.cntMode ? activeEdge : preLast);
  assign hitZero    = decrement && (count == DATA_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      trigPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], trigIn};
      trigPrev <= trigLvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= CH_IDLE;
      count     <= '0;
      tcReg     <= '0;
      preCnt    <= '0;
      zeroPulse <= 1'b0;
    end else begin
      zeroPulse <= hitZero && !cmd.halt;
      if (cmd.halt) begin
        state  <= CH_IDLE;
        preCnt <= '0;
      end else if (cmd.loadTc && state == CH_IDLE) begin
        tcReg  <= cmd.tcVal;
        count  <= cmd.tcVal;
        preCnt <= '0;
        state  <= (cfg.cntMode || !cfg.trigStart) ? CH_RUN : CH_ARMED;
      end else begin
        if (cmd.loadTc) tcReg <= cmd.tcVal;
        case (state)
          CH_ARMED: begin
            if (activeEdge) begin
              state  <= CH_RUN;
              preCnt <= '0;
            end
          end
          CH_RUN: begin
            if (!cfg.cntMode) preCnt <= preLast ? '0 : preCnt + 1'b1;
            if (decrement) count <= hitZero ? tcReg : count - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  zero_pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroPulse |=> !zeroPulse);

  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroPulse |-> count == $past(tcReg));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == CH_IDLE && !cmd.loadTc) |=> $stable(count));

  // R7
  armed_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == CH_ARMED && !cmd.halt) |=> $stable(count));
endmodule

// File: rtl/qct_datapath.sv
module qct_datapath
  import qct_pkg::*;
#(
  parameter int NUM_ZC      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FAST_LOG    = 4,
  parameter int SLOW_LOG    = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  chanCfg_t [NUM_CH-1:0]   cfgAll,
  input  logic [NUM_CH-1:0]       trigIn,
  output logic [DATA_W-1:0]       rdData,
  output logic [NUM_ZC-1:0]       zeroOut,
  output logic [NUM_CH-1:0]       zeroEv
);
  logic [DATA_W-1:0] counts [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    qct_channel #(
      .SYNC_STAGES(SYNC_STAGES),
      .FAST_LOG   (FAST_LOG),
      .SLOW_LOG   (SLOW_LOG)
    ) uChan (
      .clk      (clk),
      .rstN     (rstN),
      .cfg      (cfgAll[g]),
      .cmd      (strobe.ch[g]),
      .trigIn   (trigIn[g]),
      .count    (counts[g]),
      .zeroPulse(zeroEv[g])
    );
  end

  for (genvar z = 0; z < NUM_ZC; z++) begin : gZeroOut
    assign zeroOut[z] = zeroEv[z];
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdGo) rdData = counts[strobe.rdSel];
  end
endmodule

// File: rtl/qct_ctrl.sv
module qct_ctrl
  import qct_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cs,
  input  logic [CH_W-1:0]       chanSel,
  input  logic                  rdEn,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  intAck,
  input  logic [NUM_CH-1:0]     zeroEv,
  output dpStrobe_t             strobe,
  output chanCfg_t [NUM_CH-1:0] cfgAll,
  output logic                  irqReq,
  output logic [DATA_W-1:0]     vecOut
);
  logic                wrHit;
  logic [NUM_CH-1:0]   tcPend;
  logic [NUM_CH-1:0]   pending;
  logic [VBASE_W-1:0]  vecBase;
  logic [CH_W-1:0]     winner;

  assign wrHit = cs && wrEn;

  always_comb begin
    strobe       = '0;
    strobe.rdGo  = cs && rdEn;
    strobe.rdSel = chanSel;
    for (int i = 0; i < NUM_CH; i++) begin
      strobe.ch[i].tcVal = wrData;
      if (wrHit && chanSel == CH_W'(i)) begin
        if (tcPend[i]) strobe.ch[i].loadTc = 1'b1;
        else if (wrData[CW_FLAG]) strobe.ch[i].halt = wrData[CW_RST];
      end
    end
  end

  always_comb begin
    winner = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) winner = CH_W'(i);
    end
  end

  assign irqReq = |pending;
  assign vecOut = {vecBase, winner, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAll  <= '0;
      tcPend  <= '0;
      vecBase <= '0;
    end else if (wrHit) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (chanSel == CH_W'(i)) begin
          if (tcPend[i]) begin
            tcPend[i] <= 1'b0;
          end else if (wrData[CW_FLAG]) begin
            cfgAll[i].irqEn     <= wrData[CW_IRQ];
            cfgAll[i].cntMode   <= wrData[CW_CNT];
            cfgAll[i].slowPre   <= wrData[CW_SLOW];
            cfgAll[i].riseEdge  <= wrData[CW_RISE];
            cfgAll[i].trigStart <= wrData[CW_TRIG];
            tcPend[i]           <= wrData[CW_TCF];
          end else if (i == 0) begin
            vecBase <= wrData[DATA_W-1:CH_W+1];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        pending[i] <= (zeroEv[i] && cfgAll[i].irqEn) ||
                      (pending[i] && !(intAck && irqReq && winner == CH_W'(i)));
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gPendChk
    // R10
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pending[g] && !(intAck && winner == CH_W'(g))) |=> pending[g]);
  end

  // R10
  vec_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pending[vecOut[CH_W:1]] &&
                ((pending & ((NUM_CH'(1) << vecOut[CH_W:1]) - NUM_CH'(1))) == '0)));

  // R2
  tc_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && tcPend[chanSel]) |=> !tcPend[$past(chanSel)]);
endmodule

// File: rtl/quad_counter_timer.sv
module quad_counter_timer
  import qct_pkg::*;
#(
  parameter int NUM_ZC      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FAST_LOG    = 4,
  parameter int SLOW_LOG    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic [CH_W-1:0]   chanSel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] trigIn,
  output logic [NUM_ZC-1:0] zeroOut,
  output logic              irqReq,
  input  logic              intAck,
  output logic [DATA_W-1:0] vecOut
);
  dpStrobe_t             strobe;
  chanCfg_t [NUM_CH-1:0] cfgAll;
  logic [NUM_CH-1:0]     zeroEv;

  qct_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .cs     (cs),
    .chanSel(chanSel),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .wrData (wrData),
    .intAck (intAck),
    .zeroEv (zeroEv),
    .strobe (strobe),
    .cfgAll (cfgAll),
    .irqReq (irqReq),
    .vecOut (vecOut)
  );

  qct_datapath #(
    .NUM_ZC     (NUM_ZC),
    .SYNC_STAGES(SYNC_STAGES),
    .FAST_LOG   (FAST_LOG),
    .SLOW_LOG   (SLOW_LOG)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cfgAll (cfgAll),
    .trigIn (trigIn),
    .rdData (rdData),
    .zeroOut(zeroOut),
    .zeroEv (zeroEv)
  );
endmodule

// File: tb/quad_counter_timer_test.sv
module quad_counter_timer_test;
  localparam int CLK_PERIOD = 10;

  // fields: {rise, tc, edges, expCount, expPulses}
  localparam logic [39:0] VECS [6] = '{
    40'h01_0A_03_07_00,
    40'h00_0A_04_06_00,
    40'h01_05_05_05_01,
    40'h01_00_01_FF_00,
    40'h00_03_07_02_02,
    40'h01_02_01_01_00
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0;
  logic [1:0] chanSel = '0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [3:0] trigIn = '0;
  logic [2:0] zeroOut;
  logic       irqReq;
  logic       intAck = 1'b0;
  logic [7:0] vecOut;

  int checks = 0;
  int fails = 0;
  int zc [3] = '{0, 0, 0};
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk)
    for (int k = 0; k < 3; k++) if (zeroOut[k]) zc[k]++;

  quad_counter_timer uut (
    .clk(clk), .rstN(rstN), .cs(cs), .chanSel(chanSel), .rdEn(rdEn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .trigIn(trigIn),
    .zeroOut(zeroOut), .irqReq(irqReq), .intAck(intAck), .vecOut(vecOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wrEn = 1'b1; chanSel = 2'(ch); wrData = d;
    @(negedge clk);
    cs = 1'b0; wrEn = 1'b0;
  endtask

  task automatic rd(input int ch, output int v);
    cs = 1'b1; rdEn = 1'b1; chanSel = 2'(ch);
    #1 v = int'(rdData);
    cs = 1'b0; rdEn = 1'b0;
  endtask

  task automatic pulse(input int ch);
    trigIn[ch] = 1'b1; waitc(4);
    trigIn[ch] = 1'b0; waitc(4);
  endtask

  task automatic ack();
    intAck = 1'b1; waitc(1);
    intAck = 1'b0; waitc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, v2, base;
    waitc(3);
    rstN = 1'b1;
    waitc(1);
    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      rd(c, v);
      check("R1 count", v, 0);
    end
    check("R1 irqReq", int'(irqReq), 0);
    check("R1 zeroOut", int'(zeroOut), 0);
    check("R1 vector", int'(vecOut), 0);

    // R11 vector base on channel 0, ignored on channel 1
    wr(0, 8'hA8);
    wr(1, 8'h50);

    // R6 / R5 / R8 table: channel 1 counter mode
    foreach (VECS[i]) begin
      logic [39:0] e;
      e = VECS[i];
      wr(1, e[32] ? 8'h57 : 8'h47);
      wr(1, e[31:24]);
      base = zc[1];
      for (int n = 0; n < int'(e[23:16]); n++) pulse(1);
      waitc(2);
      rd(1, v);
      check("R6 edge count", v, int'(e[15:8]));
      check("R8 ch1 pulses", zc[1] - base, int'(e[7:0]));
    end

    // R3 read with cs low shows 0
    chanSel = 2'd1; rdEn = 1'b1;
    #1 check("R3 no select", int'(rdData), 0);
    rdEn = 1'b0;

    // R4 fast prescale on channel 0
    wr(0, 8'h07);
    wr(0, 8'd10);
    waitc(56);
    rd(0, v);
    check("R4 div16", v, 7);
    rd(0, v2);
    check("R3 reread", v2, 7);

    // R5 reload period on channel 0
    wr(0, 8'h07);
    wr(0, 8'd2);
    base = zc[0];
    waitc(136);
    rd(0, v);
    check("R5 reload count", v, 2);
    check("R8 ch0 pulses", zc[0] - base, 4);
    wr(0, 8'h03);

    // R4 slow prescale on channel 2
    wr(2, 8'h27);
    wr(2, 8'd3);
    waitc(384);
    rd(2, v);
    check("R4 div256", v, 2);

    // R7 triggered start on channel 3
    wr(3, 8'h1F);
    wr(3, 8'd5);
    waitc(100);
    rd(3, v);
    check("R7 armed hold", v, 5);
    trigIn[3] = 1'b1;
    waitc(40);
    rd(3, v);
    check("R7 after trigger", v, 3);
    trigIn[3] = 1'b0;

    // R12 new constant while running
    wr(1, 8'h57);
    wr(1, 8'd10);
    pulse(1); pulse(1);
    wr(1, 8'h55);
    wr(1, 8'd3);
    rd(1, v);
    check("R12 count kept", v, 8);
    for (int n = 0; n < 8; n++) pulse(1);
    rd(1, v);
    check("R12 new reload", v, 3);

    // R10 interrupt from channel 2
    check("R10 idle irq", int'(irqReq), 0);
    wr(2, 8'h87);
    wr(2, 8'd1);
    waitc(20);
    check("R10 irq raised", int'(irqReq), 1);
    check("R11 vector ch2", int'(vecOut), 'hAC);

    // R9 software reset keeps pending, freezes count
    wr(2, 8'h83);
    rd(2, v);
    waitc(50);
    rd(2, v2);
    check("R9 frozen", v2, 1);
    check("R9 frozen same", v2, v);
    check("R9 pending kept", int'(irqReq), 1);

    // R10 priority: channel 1 beats channel 2
    wr(1, 8'hD7);
    wr(1, 8'd1);
    pulse(1);
    check("R10 vector ch1", int'(vecOut), 'hAA);
    ack();
    check("R10 after ack1 irq", int'(irqReq), 1);
    check("R10 after ack1 vec", int'(vecOut), 'hAC);
    ack();
    check("R10 after ack2", int'(irqReq), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule